// File: doc/BRIEF.md
# Static Memory Read Timing Sequencer

This block runs read cycles on an asynchronous static memory bus with four chip-select banks. A host issues a read with a valid/ready handshake. The request carries a bank number, an address and a page-mode flag. The sequencer drives the external address and one active-low chip select, then paces the active-low output enable from per-bank timing values. It samples the returned data and hands it back to the host with a one-cycle acknowledge.

Each bank has two 5-bit timing fields:

- an assertion delay D, the number of cycles output enable stays high after the address becomes valid;
- a read delay N, after which output enable stays low for N+1 cycles.

One address-hold cycle follows, so the address stays valid for D+N+2 cycles. In page mode, only the first read of a burst pays these delays. Reads that follow it in the same bank are accepted back to back and each needs a single output-enable cycle.

The sequencer starts no access while the controller is disabled or in low-power mode. A timing-register write is accepted only while the sequencer is idle, so an access in flight always keeps its timing.

Top module: `srd_top`

## Requirements
- R1: After reset, every bank's read delay reads 31, every assertion delay reads 0, all chip selects and output enable are high, and rd_ack is low.
- R2: The timing field sits in bits 4:0 of cfg_wdata/cfg_rdata, and bits 31:5 always read as zero. cfg_sel=0 selects the assertion delay and cfg_sel=1 selects the read delay; cfg_bank selects the bank for both reading and writing.
- R3: After a request is accepted, the address and the chip select of the requested bank are valid from the next cycle, and output enable stays high for D cycles.
- R4: Output enable then stays low for N+1 cycles, and read data is captured on the final clock edge of that phase.
- R5: In the next cycle (the hold cycle), chip select stays low, output enable is high, and rd_ack is high for exactly one cycle with the captured data on rd_data.
- R6: With D=0 and N=0, an access is one output-enable cycle followed by the hold cycle.
- R7: When the first read of a burst had rd_page=1, rd_rdy rises in the hold cycle for a request with rd_page=1 to the same bank. Such a continuation read skips the assertion delay and keeps output enable low for one cycle only.
- R8: A request to another bank, or without the page flag, is not accepted in the hold cycle. It waits for idle and then gets the full D and N timing.
- R9: While ctl_enable=0 or ctl_lowpwr=1, rd_rdy stays low and no chip select is asserted.
- R10: While an access is in progress, cfg_ready is low and a pending write has no effect on the running access. The write takes effect once the sequencer is idle.
- R11: When a register write and a read request arrive together in idle, the write is taken and rd_rdy stays low in that cycle. The read then starts with the new value.
- R12: At most one chip select is low at any time, and it is the one for the bank of the current access. mem_cs_n bit b belongs to bank b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enable; 0 blocks new accesses |
| ctl_lowpwr | input | 1 | Low-power mode; 1 blocks new accesses |
| cfg_we | input | 1 | Timing register write request |
| cfg_bank | input | 2 | Bank selected for register access |
| cfg_sel | input | 1 | 0 = assertion delay, 1 = read delay |
| cfg_wdata | input | 32 | Write data; only bits 4:0 are stored |
| cfg_ready | output | 1 | High when a write is accepted (sequencer idle) |
| cfg_rdata | output | 32 | Selected field, zero-extended |
| rd_req | input | 1 | Read request valid |
| rd_bank | input | 2 | Bank of the request |
| rd_addr | input | 16 | Address of the request |
| rd_page | input | 1 | Page-mode flag |
| rd_rdy | output | 1 | Request accepted when high together with rd_req |
| rd_ack | output | 1 | One-cycle pulse with read data |
| rd_data | output | 32 | Captured read data |
| mem_addr | output | 16 | External address |
| mem_cs_n | output | 4 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_din | input | 32 | Data from memory |

## Verification
Two events can land in the same cycle in idle: a host read request and a timing-register write. The bench raises cfg_we and rd_req on the same edge. It checks that rd_rdy is low in that cycle, and that the read taken next shows the output-enable low length set by the new value. A second overlap comes from holding a write pending through a long access. The bench checks that cfg_ready stays low and that the running access keeps its old read delay. Page continuation in the hold cycle also overlaps the acknowledge of the previous read: the next request is offered while rd_ack is high, and the bench judges it by the one-cycle output enable that follows.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int FLD_W = 5;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OED  = 2'd1,
    ST_RD   = 2'd2,
    ST_HOLD = 2'd3
  } seq_st_e;
endpackage

// File: rtl/srd_rst_sync.sv
module srd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/srd_bank_regs.sv
module srd_bank_regs
  import srd_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BW     = $clog2(NB),
  parameter int RD_RST = 31,
  parameter int OE_RST = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [BW-1:0]             sel_bank,
  input  logic                      sel_rd,
  input  logic [FLD_W-1:0]          wr_fld,
  output logic [FLD_W-1:0]          rd_fld,
  output logic [NB-1:0][FLD_W-1:0]  oed_q,
  output logic [NB-1:0][FLD_W-1:0]  rdd_q
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && (sel_bank == BW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oed_q[b] <= FLD_W'(OE_RST);
        rdd_q[b] <= FLD_W'(RD_RST);
      end else begin
        if (hit && !sel_rd) oed_q[b] <= wr_fld;
        if (hit &&  sel_rd) rdd_q[b] <= wr_fld;
      end
    end
  end

  assign rd_fld = sel_rd ? rdd_q[sel_bank] : oed_q[sel_bank];
endmodule

// File: rtl/srd_seq.sv
module srd_seq
  import srd_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = $clog2(NB),
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go_ok,
  input  logic                      req,
  input  logic [BW-1:0]             req_bank,
  input  logic [AW-1:0]             req_addr,
  input  logic                      req_page,
  input  logic [NB-1:0][FLD_W-1:0]  oed_q,
  input  logic [NB-1:0][FLD_W-1:0]  rdd_q,
  input  logic [DW-1:0]             mem_din,
  output logic                      rdy,
  output logic                      idle,
  output logic                      ack,
  output logic [DW-1:0]             rdata,
  output logic [AW-1:0]             mem_addr,
  output logic [NB-1:0]             mem_cs_n,
  output logic                      mem_oe_n
);
  seq_st_e           st_q, st_d;
  logic [FLD_W-1:0]  cnt_q, cnt_d;
  logic [BW-1:0]     bank_q;
  logic [AW-1:0]     addr_q;
  logic              page_q;
  logic              ack_q;
  logic [DW-1:0]     data_q;
  logic              take, cont_ok, last_rd, load_req;

  assign cont_ok  = (st_q == ST_HOLD) && page_q && req_page &&
                    (req_bank == bank_q) && go_ok;
  assign rdy      = ((st_q == ST_IDLE) && go_ok) || cont_ok;
  assign take     = req && rdy;
  assign last_rd  = (st_q == ST_RD) && (cnt_q == '0);
  assign load_req = take;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (take) begin
        if (oed_q[req_bank] == '0) begin
          st_d  = ST_RD;
          cnt_d = rdd_q[req_bank];
        end else begin
          st_d  = ST_OED;
          cnt_d = oed_q[req_bank] - 1'b1;
        end
      end
      ST_OED: begin
        if (cnt_q == '0) begin
          st_d  = ST_RD;
          cnt_d = rdd_q[bank_q];
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RD: begin
        if (cnt_q == '0) st_d  = ST_HOLD;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_HOLD: begin
        if (take) begin
          st_d  = ST_RD;
          cnt_d = '0;
        end else begin
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bank_q <= '0;
      addr_q <= '0;
      page_q <= 1'b0;
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ack_q <= last_rd;
      if (load_req) begin
        bank_q <= req_bank;
        addr_q <= req_addr;
        page_q <= req_page;
      end
      if (last_rd) data_q <= mem_din;
    end
  end

  always_comb begin
    for (int i = 0; i < NB; i++)
      mem_cs_n[i] = !((st_q != ST_IDLE) && (bank_q == BW'(i)));
  end

  assign mem_oe_n = (st_q != ST_RD);
  assign mem_addr = addr_q;
  assign idle     = (st_q == ST_IDLE);
  assign ack      = ack_q;
  assign rdata    = data_q;
endmodule

// File: rtl/srd_top.sv
module srd_top
  import srd_pkg::*;
#(
  parameter int NB = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_enable,
  input  logic          ctl_lowpwr,
  input  logic          cfg_we,
  input  logic [BW-1:0] cfg_bank,
  input  logic          cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic          cfg_ready,
  output logic [31:0]   cfg_rdata,
  input  logic          rd_req,
  input  logic [BW-1:0] rd_bank,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_page,
  output logic          rd_rdy,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic [NB-1:0] mem_cs_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_din
);
  logic                     rst_s_n;
  logic                     seq_idle;
  logic                     go_ok;
  logic [FLD_W-1:0]         fld_rd;
  logic [NB-1:0][FLD_W-1:0] oed_q, rdd_q;

  srd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  // A write has priority over a new read in the same idle cycle.
  assign go_ok     = ctl_enable && !ctl_lowpwr && !cfg_we;
  assign cfg_ready = seq_idle;
  assign cfg_rdata = {{(32-FLD_W){1'b0}}, fld_rd};

  srd_bank_regs #(.NB(NB), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en(cfg_we && seq_idle), .sel_bank(cfg_bank), .sel_rd(cfg_sel),
    .wr_fld(cfg_wdata[FLD_W-1:0]), .rd_fld(fld_rd),
    .oed_q(oed_q), .rdd_q(rdd_q)
  );

  srd_seq #(.NB(NB), .BW(BW), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .go_ok(go_ok),
    .req(rd_req), .req_bank(rd_bank), .req_addr(rd_addr), .req_page(rd_page),
    .oed_q(oed_q), .rdd_q(rdd_q), .mem_din(mem_din),
    .rdy(rd_rdy), .idle(seq_idle), .ack(rd_ack), .rdata(rd_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n)
  );
endmodule

// File: rtl/srd_chk.sv
module srd_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_enable,
  input logic          ctl_lowpwr,
  input logic          cfg_we,
  input logic          cfg_ready,
  input logic          rd_rdy,
  input logic          rd_ack,
  input logic [NB-1:0] mem_cs_n,
  input logic          mem_oe_n
);
  a_r12_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r4_oe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> ($countones(~mem_cs_n) == 1));

  a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);

  a_r5_ack_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> (mem_oe_n && ($countones(~mem_cs_n) == 1)));

  a_r4_ack_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> !$past(mem_oe_n));

  a_r9_blocked_modes: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rdy |-> (ctl_enable && !ctl_lowpwr));

  a_r10_cfg_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> (mem_oe_n && (&mem_cs_n)));

  a_r11_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !rd_rdy);
endmodule

bind srd_top srd_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .ctl_enable(ctl_enable), .ctl_lowpwr(ctl_lowpwr),
  .cfg_we(cfg_we), .cfg_ready(cfg_ready), .rd_rdy(rd_rdy), .rd_ack(rd_ack),
  .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n)
);

// File: tb/sim_srd_top.sv
module sim_srd_top;
  localparam int NB = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_enable, ctl_lowpwr;
  logic          cfg_we;
  logic [1:0]    cfg_bank;
  logic          cfg_sel;
  logic [31:0]   cfg_wdata;
  logic          cfg_ready;
  logic [31:0]   cfg_rdata;
  logic          rd_req;
  logic [1:0]    rd_bank;
  logic [AW-1:0] rd_addr;
  logic          rd_page;
  logic          rd_rdy, rd_ack;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic [NB-1:0] mem_cs_n;
  logic          mem_oe_n;
  logic [DW-1:0] mem_din;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  assign mem_din = mem_oe_n ? '0 : pat(mem_addr);

  srd_top u0 (.*);

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic cfg_write(input int b, input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 2'(b); cfg_sel = sel; cfg_wdata = d;
    for (int g = 0; g < 500 && !cfg_ready; g++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input int b, input bit sel, output logic [31:0] v);
    @(negedge clk);
    cfg_bank = 2'(b); cfg_sel = sel;
    #1 v = cfg_rdata;
  endtask

  // Caller is at a negedge. Ends at the negedge inside the hold cycle.
  task automatic access(input int b, input logic [AW-1:0] a, input bit pg,
                        input int expD, input int expN, input string rq);
    int hi, lo;
    rd_req = 1'b1; rd_bank = 2'(b); rd_addr = a; rd_page = pg;
    #1;
    for (int g = 0; g < 500 && !rd_rdy; g++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0; rd_page = 1'b0;
    hi = 0;
    while (mem_oe_n && !rd_ack && hi < 100) begin
      chk(mem_cs_n == ~(4'b1 << b) && mem_addr == a, {rq, " cs/addr"}, mem_cs_n, ~(4'b1 << b));
      hi++; @(negedge clk);
    end
    lo = 0;
    while (!mem_oe_n && lo < 100) begin lo++; @(negedge clk); end
    chk(hi == expD, {rq, " oe high cycles R3"}, hi, expD);
    chk(lo == expN + 1, {rq, " oe low cycles R4"}, lo, expN + 1);
    chk(rd_ack && mem_oe_n && mem_cs_n == ~(4'b1 << b), {rq, " hold/ack R5"}, rd_ack, 1);
    chk(rd_data == pat(a), {rq, " data R4"}, rd_data, pat(a));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(mem_cs_n == 4'hF && mem_oe_n && !rd_ack, "R1 bus idle", {mem_cs_n, mem_oe_n}, 5'h1F);
    for (int b = 0; b < NB; b++) begin
      cfg_read(b, 1'b1, v); chk(v == 32'd31, "R1 read delay reset", v, 31);
      cfg_read(b, 1'b0, v); chk(v == 32'd0, "R1 assert delay reset", v, 0);
    end
  endtask

  task automatic t_regs;
    logic [31:0] v;
    cfg_write(2, 1'b1, 32'hFFFF_FFE3);
    cfg_read(2, 1'b1, v); chk(v == 32'd3, "R2 field bits", v, 3);
    cfg_write(2, 1'b0, 32'h0000_0007);
    cfg_read(2, 1'b0, v); chk(v == 32'd7, "R2 sel 0", v, 7);
    cfg_read(1, 1'b1, v); chk(v == 32'd31, "R2 other bank untouched", v, 31);
    @(negedge clk);
    access(2, 16'h1234, 1'b0, 7, 3, "R12 bank2");
    @(negedge clk);
  endtask

  task automatic t_timing;
    access(3, 16'hBEEF, 1'b0, 0, 31, "R4 default delay");
    @(negedge clk);
    cfg_write(0, 1'b1, 0);
    access(0, 16'h0042, 1'b0, 0, 0, "R6 zero wait");
    @(negedge clk);
    cfg_write(1, 1'b0, 2);
    cfg_write(1, 1'b1, 3);
    access(1, 16'h0100, 1'b0, 2, 3, "R3 delayed oe");
    @(negedge clk);
  endtask

  task automatic t_page;
    access(1, 16'h0200, 1'b1, 2, 3, "R7 first page read");
    access(1, 16'h0201, 1'b1, 0, 0, "R7 page cont 1");
    access(1, 16'h0202, 1'b1, 0, 0, "R7 page cont 2");
    rd_req = 1'b1; rd_bank = 2'd0; rd_addr = 16'h0300; rd_page = 1'b1;
    #1 chk(!rd_rdy, "R8 bank change in hold", rd_rdy, 0);
    rd_req = 1'b0;
    @(negedge clk);
    chk(mem_cs_n == 4'hF, "R8 back to idle", mem_cs_n, 4'hF);
    access(1, 16'h0203, 1'b0, 2, 3, "R8 full timing after burst");
    @(negedge clk);
  endtask

  task automatic t_modes;
    ctl_enable = 1'b0;
    @(negedge clk);
    rd_req = 1'b1; rd_bank = 2'd0; rd_addr = 16'h0055;
    repeat (5) begin
      #1 chk(!rd_rdy && mem_cs_n == 4'hF, "R9 disabled", rd_rdy, 0);
      @(negedge clk);
    end
    ctl_enable = 1'b1; ctl_lowpwr = 1'b1;
    repeat (5) begin
      #1 chk(!rd_rdy && mem_cs_n == 4'hF && !rd_ack, "R9 low power", rd_rdy, 0);
      @(negedge clk);
    end
    rd_req = 1'b0; ctl_lowpwr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_held_write;
    logic [31:0] v;
    cfg_write(2, 1'b0, 1);
    cfg_write(2, 1'b1, 10);
    fork
      access(2, 16'h0777, 1'b0, 1, 10, "R10 access keeps timing");
      begin
        repeat (3) @(negedge clk);
        #2 chk(!cfg_ready, "R10 ready low while busy", cfg_ready, 0);
        cfg_write(2, 1'b1, 0);
      end
    join
    @(negedge clk);
    cfg_read(2, 1'b1, v); chk(v == 32'd0, "R10 write applied after", v, 0);
    @(negedge clk);
    access(2, 16'h0778, 1'b0, 1, 0, "R10 new timing");
    @(negedge clk);
  endtask

  task automatic t_collision;
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 2'd0; cfg_sel = 1'b1; cfg_wdata = 32'd2;
    rd_req = 1'b1; rd_bank = 2'd0; rd_addr = 16'h0A0A; rd_page = 1'b0;
    #1 chk(!rd_rdy, "R11 write wins", rd_rdy, 0);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(mem_cs_n == 4'hF, "R11 no access started", mem_cs_n, 4'hF);
    access(0, 16'h0A0A, 1'b0, 0, 2, "R11 read uses new value");
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_enable = 1'b1; ctl_lowpwr = 1'b0;
    cfg_we = 1'b0; cfg_bank = '0; cfg_sel = 1'b0; cfg_wdata = '0;
    rd_req = 1'b0; rd_bank = '0; rd_addr = '0; rd_page = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regs;
    t_timing;
    t_page;
    t_modes;
    t_held_write;
    t_collision;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule